// File: doc/BRIEF.md
# Paged Host Window onto a Trace Buffer

This block lets a 16-bit host bus read a trace buffer larger than 64 KB through a fixed 64 KB memory window in the host's physical address space. A two-bit page register, loaded through an I/O port, chooses which 64 KB slice of the 256 KB buffer shows through the window. A single bit in the same port moves the window between the D000h segment (the default) and the E000h segment, so the window can avoid another adapter that already uses D000h.

Software reads the buffer as four successive 64 KB transfers and writes the page register before each one. After the last transfer it writes the command port. That write produces a one-cycle clear pulse toward the fill controller, which empties the buffer and lets the traced system resume. The same write returns the page register to 0. The buffer is a synchronous memory of 64-bit words with one cycle of read latency. The block forms the word address from the page and the window offset, then steers the addressed 16-bit lane back to the host.

Top module: `pgwin_top`

## Requirements
- R1: After reset the page is 0, the window base is D000h, `clear_pulse` is 0 and `host_rvalid` is 0.
- R2: With the base bit at 0, a memory read whose address bits [19:16] equal 4'hD asserts `buf_rd_en` in the same cycle. A memory read anywhere else asserts neither `buf_rd_en` nor, later, `host_rvalid`.
- R3: With the base bit at 1, the window decodes at bits [19:16] equal to 4'hE, and addresses in the D000h segment are no longer claimed.
- R4: The 64-bit word address on `buf_rd_addr` is {page[1:0], offset[15:3]}, where offset is the host address bits [15:0].
- R5: Offset bits [2:1] pick the 16-bit lane of the buffer word. Lane 0 is bits [15:0] and lane 3 is bits [63:48].
- R6: Read data appears on `host_rdata` with `host_rvalid` high for one cycle, two clock edges after the edge that samples the read strobe. This applies to window reads and control-port reads alike.
- R7: An I/O write to the control port (0x0300) loads the page from data bits [1:0] and the base bit from data bit 4. An I/O read of that port returns the page in bits [1:0], the base bit in bit 4 and zero elsewhere.
- R8: Memory writes inside the window are ignored. They cause no buffer access and no read response, and they do not change the page or base.
- R9: An I/O write to the command port (0x0302) with data bit 0 set makes `clear_pulse` high for exactly the one cycle after the sampling edge. It also resets the page to 0 and leaves the base bit unchanged.
- R10: A command-port write with data bit 0 clear produces no pulse and changes no register.
- R11: I/O accesses to any other port, and reads of the command port, produce no response and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 20 | Host physical address; bits [15:0] also form the I/O port number |
| host_wdata | input | 16 | Host write data for I/O writes |
| host_mem_rd | input | 1 | Memory read strobe, one cycle per access |
| host_mem_wr | input | 1 | Memory write strobe, one cycle per access |
| host_io_rd | input | 1 | I/O read strobe, one cycle per access |
| host_io_wr | input | 1 | I/O write strobe, one cycle per access |
| host_rdata | output | 16 | Read data returned to the host |
| host_rvalid | output | 1 | Marks the cycle in which host_rdata is valid |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | 15 | Buffer 64-bit word address |
| buf_rd_data | input | 64 | Buffer word, valid the cycle after buf_rd_en |
| clear_pulse | output | 1 | One-cycle clear-and-resume command to the fill controller |

## Verification
A corrupted page register shows up at once in the upper two bits of `buf_rd_addr` on the next window read. It is also visible two edges later when the control port is read back. A wrong base bit makes a window read miss outright, so `host_rvalid` never rises. A wrong lane select or a slip in the two-stage return pipeline shows as a wrong `host_rdata` value or a misplaced `host_rvalid`, exactly two edges after the read. A clear pulse that is missing or too long can be seen in the single cycle after the command write.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  // Bit positions inside the I/O data word
  localparam int unsigned CTRL_BASE_BIT = 4;
  localparam int unsigned CMD_CLEAR_BIT = 0;

  // Kind of read response travelling down the return pipeline
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_BUF  = 2'd1,
    RSP_CTRL = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned IO_W    = 16,
  parameter int unsigned IO_BASE = 'h0300,
  parameter int unsigned SEG_A   = 'hD,
  parameter int unsigned SEG_B   = 'hE
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_mem_rd,
  input  logic              host_io_rd,
  input  logic              host_io_wr,
  input  logic              base_sel,
  output logic              win_rd,
  output logic              ctrl_rd,
  output logic              ctrl_wr,
  output logic              cmd_wr
);
  localparam int unsigned SEG_W = ADDR_W - WIN_W;

  logic [SEG_W-1:0] seg_now;
  logic [SEG_W-1:0] seg_sel;
  logic [IO_W-1:0]  io_port;
  logic             win_hit;
  logic             ctrl_hit;
  logic             cmd_hit;

  always_comb begin
    seg_now  = host_addr[ADDR_W-1:WIN_W];
    seg_sel  = base_sel ? SEG_W'(SEG_B) : SEG_W'(SEG_A);
    win_hit  = (seg_now == seg_sel);
    io_port  = host_addr[IO_W-1:0];
    ctrl_hit = (io_port == IO_W'(IO_BASE));
    cmd_hit  = (io_port == IO_W'(IO_BASE + 2));
    // Memory writes are never decoded: the window is read-only.
    win_rd   = host_mem_rd & win_hit;
    ctrl_rd  = host_io_rd & ctrl_hit;
    ctrl_wr  = host_io_wr & ctrl_hit;
    cmd_wr   = host_io_wr & cmd_hit;
  end
endmodule

// File: rtl/pgwin_regs.sv
module pgwin_regs
  import pgwin_pkg::*;
#(
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned HOST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              cmd_wr,
  input  logic [HOST_W-1:0] wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              base_q,
  output logic              clear_q
);
  logic [PAGE_W-1:0] page_d;
  logic              base_d;
  logic              clear_d;
  logic              do_clear;
  logic              reg_en;

  always_comb begin
    do_clear = cmd_wr & wdata[CMD_CLEAR_BIT];
    reg_en   = ctrl_wr | do_clear;
    page_d   = page_q;
    base_d   = base_q;
    clear_d  = do_clear;
    if (do_clear) begin
      page_d = '0;
    end else if (ctrl_wr) begin
      page_d = wdata[PAGE_W-1:0];
      base_d = wdata[CTRL_BASE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      base_q <= 1'b0;
    end else if (reg_en) begin
      page_q <= page_d;
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clear_q <= 1'b0;
    else        clear_q <= clear_d;
  end
endmodule

// File: rtl/pgwin_steer.sv
module pgwin_steer
  import pgwin_pkg::*;
#(
  parameter int unsigned HOST_W = 16,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rsp_kind_e         req_kind,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [HOST_W-1:0] ctrl_rdata,
  input  logic [WORD_W-1:0] buf_rd_data,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid
);
  localparam int unsigned LANES = WORD_W / HOST_W;

  rsp_kind_e         kind_q;
  logic [LANE_W-1:0] lane_q;
  logic [HOST_W-1:0] ctrl_q;
  logic              s1_en;
  logic [HOST_W-1:0] lane_arr [LANES];
  logic [HOST_W-1:0] lane_pick;
  logic [HOST_W-1:0] rdata_d;
  logic              rvalid_d;
  logic              out_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_arr[g] = buf_rd_data[g*HOST_W +: HOST_W];
  end

  always_comb begin
    s1_en     = (req_kind != RSP_NONE);
    lane_pick = lane_arr[lane_q];
    rvalid_d  = (kind_q != RSP_NONE);
    out_en    = rvalid_d;
    rdata_d   = (kind_q == RSP_BUF) ? lane_pick : ctrl_q;
  end

  // Stage 1: remember what the pending response is while the buffer reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= RSP_NONE;
    else        kind_q <= req_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      ctrl_q <= '0;
    end else if (s1_en) begin
      lane_q <= req_lane;
      ctrl_q <= ctrl_rdata;
    end
  end

  // Stage 2: registered output toward the host
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= rvalid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_rdata <= '0;
    else if (out_en) host_rdata <= rdata_d;
  end
endmodule

// File: rtl/pgwin_top.sv
module pgwin_top
  import pgwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned HOST_W  = 16,
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned IO_BASE = 'h0300,
  parameter int unsigned SEG_A   = 'hD,
  parameter int unsigned SEG_B   = 'hE,
  localparam int unsigned BYTE_LSB = $clog2(WORD_W / 8),
  localparam int unsigned BUF_AW   = PAGE_W + WIN_W - BYTE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_mem_rd,
  input  logic              host_mem_wr,
  input  logic              host_io_rd,
  input  logic              host_io_wr,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              buf_rd_en,
  output logic [BUF_AW-1:0] buf_rd_addr,
  input  logic [WORD_W-1:0] buf_rd_data,
  output logic              clear_pulse
);
  localparam int unsigned LANES   = WORD_W / HOST_W;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned LANE_HI = BYTE_LSB - 1;
  localparam int unsigned IO_W    = 16;

  logic              win_rd;
  logic              ctrl_rd;
  logic              ctrl_wr;
  logic              cmd_wr;
  logic [PAGE_W-1:0] page_q;
  logic              base_q;
  logic [HOST_W-1:0] ctrl_rdata;
  logic [LANE_W-1:0] req_lane;
  rsp_kind_e         req_kind;
  logic              unused_wr;

  pgwin_decode #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .IO_W   (IO_W),
    .IO_BASE(IO_BASE),
    .SEG_A  (SEG_A),
    .SEG_B  (SEG_B)
  ) u_decode (
    .host_addr  (host_addr),
    .host_mem_rd(host_mem_rd),
    .host_io_rd (host_io_rd),
    .host_io_wr (host_io_wr),
    .base_sel   (base_q),
    .win_rd     (win_rd),
    .ctrl_rd    (ctrl_rd),
    .ctrl_wr    (ctrl_wr),
    .cmd_wr     (cmd_wr)
  );

  pgwin_regs #(
    .PAGE_W(PAGE_W),
    .HOST_W(HOST_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(ctrl_wr),
    .cmd_wr (cmd_wr),
    .wdata  (host_wdata),
    .page_q (page_q),
    .base_q (base_q),
    .clear_q(clear_pulse)
  );

  always_comb begin
    // Memory writes have no path into this block.
    unused_wr   = host_mem_wr;
    buf_rd_en   = win_rd;
    buf_rd_addr = {page_q, host_addr[WIN_W-1:BYTE_LSB]};
    req_lane    = host_addr[LANE_HI -: LANE_W];
    ctrl_rdata  = '0;
    ctrl_rdata[PAGE_W-1:0]    = page_q;
    ctrl_rdata[CTRL_BASE_BIT] = base_q;
    if (win_rd)       req_kind = RSP_BUF;
    else if (ctrl_rd) req_kind = RSP_CTRL;
    else              req_kind = RSP_NONE;
  end

  pgwin_steer #(
    .HOST_W(HOST_W),
    .WORD_W(WORD_W),
    .LANE_W(LANE_W)
  ) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_kind   (req_kind),
    .req_lane   (req_lane),
    .ctrl_rdata (ctrl_rdata),
    .buf_rd_data(buf_rd_data),
    .host_rdata (host_rdata),
    .host_rvalid(host_rvalid)
  );
endmodule

// File: rtl/pgwin_checker.sv
module pgwin_checker #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned HOST_W  = 16,
  parameter int unsigned IO_BASE = 'h0300,
  parameter int unsigned SEG_A   = 'hD,
  parameter int unsigned SEG_B   = 'hE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [HOST_W-1:0] host_wdata,
  input logic              host_mem_rd,
  input logic              host_io_rd,
  input logic              host_io_wr,
  input logic              host_rvalid,
  input logic              buf_rd_en,
  input logic              clear_pulse,
  input logic [PAGE_W-1:0] page_q,
  input logic              base_q
);
  localparam int unsigned SEG_W = ADDR_W - WIN_W;

  // R9: a clear pulse is caused only by a command write with bit 0 set
  a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> $past(host_io_wr && (host_addr[15:0] == 16'(IO_BASE + 2)) && host_wdata[0]));

  // R9: the page is back at 0 while the clear pulse is high
  a_r9_clear_page: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> (page_q == '0));

  // R6: a response follows a read strobe two edges earlier
  a_r6_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_mem_rd || host_io_rd, 2));

  // R8: without a memory read there is no buffer access
  a_r8_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mem_rd |-> !buf_rd_en);

  // R3: a buffer access only happens inside the selected segment
  a_r3_window_seg: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> (host_addr[ADDR_W-1:WIN_W] == (base_q ? SEG_W'(SEG_B) : SEG_W'(SEG_A))));

  // R7: page and base change only after an I/O write
  a_r7_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_io_wr |=> ($stable(page_q) && $stable(base_q)));
endmodule

bind pgwin_top pgwin_checker #(
  .ADDR_W (ADDR_W),
  .WIN_W  (WIN_W),
  .PAGE_W (PAGE_W),
  .HOST_W (HOST_W),
  .IO_BASE(IO_BASE),
  .SEG_A  (SEG_A),
  .SEG_B  (SEG_B)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_mem_rd(host_mem_rd),
  .host_io_rd (host_io_rd),
  .host_io_wr (host_io_wr),
  .host_rvalid(host_rvalid),
  .buf_rd_en  (buf_rd_en),
  .clear_pulse(clear_pulse),
  .page_q     (page_q),
  .base_q     (base_q)
);

// File: tb/pgwin_top_bench.sv
`timescale 1ns/1ps
module pgwin_top_bench;
  logic        clk;
  logic        rst_n;
  logic [19:0] host_addr;
  logic [15:0] host_wdata;
  logic        host_mem_rd;
  logic        host_mem_wr;
  logic        host_io_rd;
  logic        host_io_wr;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        buf_rd_en;
  logic [14:0] buf_rd_addr;
  logic [63:0] buf_rd_data;
  logic        clear_pulse;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  localparam logic [15:0] CTRL_PORT = 16'h0300;
  localparam logic [15:0] CMD_PORT  = 16'h0302;

  pgwin_top u_pgwin_top (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_mem_rd(host_mem_rd), .host_mem_wr(host_mem_wr),
    .host_io_rd(host_io_rd), .host_io_wr(host_io_wr),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data), .clear_pulse(clear_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Lane content of the buffer model: {lane, low 14 bits of word address}
  function automatic logic [15:0] pat(input logic [14:0] w, input logic [1:0] l);
    return {l, w[13:0]};
  endfunction

  // Buffer model: synchronous read, one cycle latency
  always_ff @(posedge clk) begin
    if (buf_rd_en)
      buf_rd_data <= {pat(buf_rd_addr, 2'd3), pat(buf_rd_addr, 2'd2),
                      pat(buf_rd_addr, 2'd1), pat(buf_rd_addr, 2'd0)};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory read: returns same-cycle buffer request view and the response
  task automatic mem_read(input logic [19:0] a, output logic en, output logic [14:0] wa,
                          output logic early, output logic vld, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_mem_rd = 1'b1;
    #0.5; en = buf_rd_en; wa = buf_rd_addr;
    @(negedge clk);
    host_mem_rd = 1'b0; early = host_rvalid;
    @(negedge clk);
    vld = host_rvalid; d = host_rdata;
  endtask

  task automatic io_read(input logic [15:0] p, output logic vld, output logic [15:0] d);
    @(negedge clk);
    host_addr = {4'h0, p}; host_io_rd = 1'b1;
    @(negedge clk);
    host_io_rd = 1'b0;
    @(negedge clk);
    vld = host_rvalid; d = host_rdata;
  endtask

  // I/O write: reports clear_pulse in the cycle after the write and the one after that
  task automatic io_write(input logic [15:0] p, input logic [15:0] v,
                          output logic clr1, output logic clr2);
    @(negedge clk);
    host_addr = {4'h0, p}; host_wdata = v; host_io_wr = 1'b1;
    @(negedge clk);
    host_io_wr = 1'b0; clr1 = clear_pulse;
    @(negedge clk);
    clr2 = clear_pulse;
  endtask

  task automatic read_ctrl(input string req, input logic [15:0] exp);
    logic v; logic [15:0] d;
    io_read(CTRL_PORT, v, d);
    chk(v === 1'b1 && d === exp, req, {15'b0, v, d}, {16'h1, exp});
  endtask

  task automatic t_reset();
    chk(clear_pulse === 1'b0, "R1 clear low", 32'(clear_pulse), 0);
    chk(host_rvalid === 1'b0, "R1 rvalid low", 32'(host_rvalid), 0);
    read_ctrl("R1 page0 baseD", 16'h0000);
  endtask

  task automatic t_default_window();
    logic en, early, v; logic [14:0] wa; logic [15:0] d;
    mem_read(20'hD0010, en, wa, early, v, d);
    chk(en === 1'b1, "R2 D000 claimed", 32'(en), 1);
    chk(wa === 15'h0002, "R4 word addr page0", 32'(wa), 32'h2);
    chk(early === 1'b0 && v === 1'b1, "R6 latency", {early, v}, 2'b01);
    chk(d === pat(15'h0002, 2'd0), "R5 lane0", 32'(d), 32'(pat(15'h0002, 2'd0)));
    mem_read(20'hC0010, en, wa, early, v, d);
    chk(en === 1'b0 && v === 1'b0, "R2 outside ignored", {en, v}, 0);
    mem_read(20'hE0010, en, wa, early, v, d);
    chk(en === 1'b0 && v === 1'b0, "R2 E000 not claimed", {en, v}, 0);
  endtask

  task automatic t_lanes();
    logic en, early, v; logic [14:0] wa; logic [15:0] d;
    for (int l = 0; l < 4; l++) begin
      mem_read(20'hDFFF8 | 20'(l * 2), en, wa, early, v, d);
      chk(v === 1'b1 && d === pat(15'h1FFF, 2'(l)), "R5 lane select",
          32'(d), 32'(pat(15'h1FFF, 2'(l))));
    end
    mem_read(20'hD1237, en, wa, early, v, d);
    chk(d === pat(15'h0246, 2'd3), "R5 odd byte lane3", 32'(d), 32'(pat(15'h0246, 2'd3)));
  endtask

  task automatic t_pages();
    logic en, early, v, c1, c2; logic [14:0] wa; logic [15:0] d;
    for (int p = 0; p < 4; p++) begin
      io_write(CTRL_PORT, 16'(p), c1, c2);
      read_ctrl("R7 page readback", 16'(p));
      mem_read(20'hD8008, en, wa, early, v, d);
      chk(en === 1'b1 && wa === {2'(p), 13'h1001}, "R4 page in addr",
          32'(wa), 32'({2'(p), 13'h1001}));
    end
  endtask

  task automatic t_relocate();
    logic en, early, v, c1, c2; logic [14:0] wa; logic [15:0] d;
    io_write(CTRL_PORT, 16'h0011, c1, c2);
    read_ctrl("R7 base bit readback", 16'h0011);
    mem_read(20'hE0020, en, wa, early, v, d);
    chk(en === 1'b1 && wa === 15'h2004, "R3 E000 claimed", 32'(wa), 32'h2004);
    chk(v === 1'b1 && d === pat(15'h2004, 2'd0), "R3 E000 data", 32'(d), 32'(pat(15'h2004, 2'd0)));
    mem_read(20'hD0020, en, wa, early, v, d);
    chk(en === 1'b0 && v === 1'b0, "R3 D000 released", {en, v}, 0);
  endtask

  task automatic t_writes_ignored();
    logic v; logic [15:0] d;
    @(negedge clk);
    host_addr = 20'hE0000; host_wdata = 16'hFFFF; host_mem_wr = 1'b1;
    #0.5;
    chk(buf_rd_en === 1'b0, "R8 no buffer access", 32'(buf_rd_en), 0);
    @(negedge clk);
    host_mem_wr = 1'b0;
    @(negedge clk);
    chk(host_rvalid === 1'b0, "R8 no response", 32'(host_rvalid), 0);
    read_ctrl("R8 regs unchanged", 16'h0011);
  endtask

  task automatic t_other_io();
    logic v, c1, c2; logic [15:0] d;
    io_write(16'h0304, 16'h0002, c1, c2);
    chk(c1 === 1'b0, "R11 other port no pulse", 32'(c1), 0);
    io_write(16'h0301, 16'h0000, c1, c2);
    io_read(16'h0304, v, d);
    chk(v === 1'b0, "R11 other port no reply", 32'(v), 0);
    io_read(CMD_PORT, v, d);
    chk(v === 1'b0, "R11 command read no reply", 32'(v), 0);
    read_ctrl("R11 regs unchanged", 16'h0011);
  endtask

  task automatic t_clear();
    logic c1, c2;
    io_write(CMD_PORT, 16'hFFFE, c1, c2);
    chk(c1 === 1'b0 && c2 === 1'b0, "R10 bit0 clear no pulse", {c1, c2}, 0);
    read_ctrl("R10 regs unchanged", 16'h0011);
    io_write(CTRL_PORT, 16'h0013, c1, c2);
    io_write(CMD_PORT, 16'h0001, c1, c2);
    chk(c1 === 1'b1, "R9 pulse after write", 32'(c1), 1);
    chk(c2 === 1'b0, "R9 pulse one cycle", 32'(c2), 0);
    read_ctrl("R9 page0 base kept", 16'h0010);
  endtask

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wdata = '0;
    host_mem_rd = 1'b0; host_mem_wr = 1'b0; host_io_rd = 1'b0; host_io_wr = 1'b0;
    buf_rd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_window();
    t_lanes();
    t_pages();
    t_relocate();
    t_writes_ignored();
    t_other_io();
    t_clear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule